// File: doc/BRIEF.md
# Performance Counter Overflow Interrupt Unit

This block holds a bank of programmable event counters. Each counter has a select register that carries an event code and a sticky overflow flag. Every cycle the core presents one increment bit per counter. When a counter steps past its all-ones value, its flag is set. A rising flag raises a local overflow pending bit, and together with an enable bit that pending bit drives an interrupt request.

Software reaches every piece of state through a single register port. The port carries a write strobe, a register-kind selector, a counter index and a data word. Read data is combinational from the addressed register.

Counter indices 0 to 2 are reserved for the fixed cycle and retired-instruction counters. Those counters live outside this unit, so they have no flag and never contribute to the interrupt. A summary register gathers all flags into one word. It shows a flag only where the matching bit of an enable mask is set, and only to supervisor-level or higher code.

Top module: `ovf_irq_unit`

## Requirements
- R1: After reset, every counter, event code, flag, enable-mask bit, pending bit and interrupt-enable bit is zero, and `irq_o` is low.
- R2: Each programmable counter (indices 3..31, selector 0) adds its increment bit on every cycle. If a write to that counter happens in the same cycle, the written value is loaded instead. Either way, the new value is readable after one clock edge.
- R3: When a counter at all-ones takes an increment, it wraps to zero and its flag sets. The flag is bit 63 of the select register (selector 1). It stays set until software writes that register.
- R4: A write to a select register loads bits 7:0 as the event code and bit 63 as the flag. If the counter overflows in the same cycle, the written flag value still wins.
- R5: The summary register (selector 2) has bit X equal to flag X AND enable-mask bit X when `priv_i` is not user (2'b00). In user mode it reads all zero. The enable mask (selector 3, bits 31:0) is read-write.
- R6: The pending bit sets in any cycle in which some flag goes from 0 to 1, whether by overflow or by a software write.
- R7: The pending bit is bit 13 of the pending register (selector 4). Software may set or clear it, and a write wins over a same-cycle flag rise. Once set, it holds until written, and clearing it leaves the flags unchanged.
- R8: `irq_o` is high exactly when the pending bit and the interrupt-enable bit (selector 5, bit 13) are both 1.
- R9: Indices 0..2 hold no counter. Counter and select writes to them are ignored, and reads of them return zero. Summary bits 0..2 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_i | input | 2 | Current privilege level, 2'b00 = user |
| ev_inc_i | input | 29 | Per-cycle increment, bit k feeds counter k+3 |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 3 | Register kind: 0 counter, 1 select, 2 summary, 3 mask, 4 pending, 5 interrupt enable |
| csr_idx_i | input | 5 | Counter index for kinds 0 and 1 |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data of the addressed register |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Read data depends only on the address and on registered state, so a read result is due in the same cycle. The bench samples it a short delay after the falling edge, once the inputs have been driven. A write, an increment, a wrap and its flag, and the pending bit that the flag raises all land on the next rising edge. The behavioural model therefore applies each cycle's stimulus only after that edge, and the next comparison happens at the following falling edge. `irq_o` is compared every cycle against the model's pending and enable bits from the same cycle.

// File: rtl/ovf_pkg.sv
package ovf_pkg;
    typedef enum logic [2:0] {
        SEL_CNT  = 3'd0,
        SEL_EVT  = 3'd1,
        SEL_SUM  = 3'd2,
        SEL_MASK = 3'd3,
        SEL_PEND = 3'd4,
        SEL_IEN  = 3'd5
    } csr_sel_e;

    localparam logic [1:0] PRIV_USER = 2'b00;
endpackage

// File: rtl/ovf_ctr_slice.sv
module ovf_ctr_slice #(
    parameter int CW  = 64,
    parameter int EVW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          cnt_we_i,
    input  logic          evt_we_i,
    input  logic [CW-1:0] wdata_i,
    output logic [CW-1:0] cnt_o,
    output logic [EVW-1:0] evs_o,
    output logic          of_o,
    output logic          of_rise_o
);
    typedef struct packed {
        logic [CW-1:0]  cnt;
        logic [EVW-1:0] evs;
        logic           of;
    } slice_st_t;

    slice_st_t st_d, st_q;
    logic      wrap_d;

    always_comb begin
        st_d   = st_q;
        wrap_d = inc_i && !cnt_we_i && (&st_q.cnt);
        if (cnt_we_i) begin
            st_d.cnt = wdata_i;
        end else begin
            st_d.cnt = st_q.cnt + CW'(inc_i);
        end
        if (evt_we_i) begin
            st_d.of  = wdata_i[CW-1];
            st_d.evs = wdata_i[EVW-1:0];
        end else begin
            st_d.of  = st_q.of | wrap_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign evs_o     = st_q.evs;
    assign of_o      = st_q.of;
    assign of_rise_o = st_d.of & ~st_q.of;

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !cnt_we_i && !evt_we_i && (&cnt_o)) |=> (of_o && cnt_o == '0)); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (of_o && !evt_we_i) |=> of_o); // R3
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_we_i |=> (of_o == $past(wdata_i[CW-1]))); // R4
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we_i |=> (cnt_o == $past(wdata_i))); // R2
endmodule

// File: rtl/ovf_pend.sv
module ovf_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic pend_we_i,
    input  logic ien_we_i,
    input  logic wbit_i,
    output logic pend_o,
    output logic ien_o,
    output logic irq_o
);
    typedef struct packed {
        logic pend;
        logic ien;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pend_we_i) begin
            st_d.pend = wbit_i;
        end else if (rise_i) begin
            st_d.pend = 1'b1;
        end
        if (ien_we_i) begin
            st_d.ien = wbit_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign ien_o  = st_q.ien;
    assign irq_o  = st_q.pend & st_q.ien;

    AST_PEND_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !pend_we_i) |=> pend_o); // R6
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !pend_we_i) |=> pend_o); // R7
    AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_o && ien_o)); // R8
endmodule

// File: rtl/ovf_irq_unit.sv
module ovf_irq_unit #(
    parameter int NCNT  = 32,
    parameter int FIRST = 3,
    parameter int CW    = 64,
    parameter int EVW   = 8,
    parameter int PBIT  = 13,
    localparam int NPROG = NCNT - FIRST,
    localparam int IDXW  = $clog2(NCNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       priv_i,
    input  logic [NPROG-1:0] ev_inc_i,
    input  logic             csr_we_i,
    input  logic [2:0]       csr_sel_i,
    input  logic [IDXW-1:0]  csr_idx_i,
    input  logic [CW-1:0]    csr_wdata_i,
    output logic [CW-1:0]    csr_rdata_o,
    output logic             irq_o
);
    import ovf_pkg::*;

    typedef struct packed {
        logic [NCNT-1:0] mask;
    } top_st_t;

    top_st_t          st_d, st_q;
    csr_sel_e         sel;
    logic [CW-1:0]    cnt_arr [NCNT];
    logic [EVW-1:0]   evs_arr [NCNT];
    logic [NCNT-1:0]  of_vec;
    logic [NCNT-1:0]  rise_vec;
    logic [NCNT-1:0]  cnt_we;
    logic [NCNT-1:0]  evt_we;
    logic             pend;
    logic             ien;
    logic             user_mode;

    assign sel       = csr_sel_e'(csr_sel_i);
    assign user_mode = (priv_i == PRIV_USER);

    for (genvar g = 0; g < NCNT; g++) begin : g_ctr
        assign cnt_we[g] = csr_we_i && (sel == SEL_CNT) && (csr_idx_i == IDXW'(g));
        assign evt_we[g] = csr_we_i && (sel == SEL_EVT) && (csr_idx_i == IDXW'(g));
        if (g >= FIRST) begin : g_prog
            ovf_ctr_slice #(.CW(CW), .EVW(EVW)) u_slice (
                .clk       (clk),
                .rst_n     (rst_n),
                .inc_i     (ev_inc_i[g-FIRST]),
                .cnt_we_i  (cnt_we[g]),
                .evt_we_i  (evt_we[g]),
                .wdata_i   (csr_wdata_i),
                .cnt_o     (cnt_arr[g]),
                .evs_o     (evs_arr[g]),
                .of_o      (of_vec[g]),
                .of_rise_o (rise_vec[g])
            );
        end else begin : g_fixed
            assign cnt_arr[g]  = '0;
            assign evs_arr[g]  = '0;
            assign of_vec[g]   = 1'b0;
            assign rise_vec[g] = 1'b0;
        end
    end

    ovf_pend u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (|rise_vec),
        .pend_we_i (csr_we_i && (sel == SEL_PEND)),
        .ien_we_i  (csr_we_i && (sel == SEL_IEN)),
        .wbit_i    (csr_wdata_i[PBIT]),
        .pend_o    (pend),
        .ien_o     (ien),
        .irq_o     (irq_o)
    );

    always_comb begin
        st_d = st_q;
        if (csr_we_i && (sel == SEL_MASK)) begin
            st_d.mask = csr_wdata_i[NCNT-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        csr_rdata_o = '0;
        unique case (sel)
            SEL_CNT:  csr_rdata_o = cnt_arr[csr_idx_i];
            SEL_EVT:  begin
                csr_rdata_o[CW-1]    = of_vec[csr_idx_i];
                csr_rdata_o[EVW-1:0] = evs_arr[csr_idx_i];
            end
            SEL_SUM:  csr_rdata_o = user_mode ? '0 : CW'(of_vec & st_q.mask);
            SEL_MASK: csr_rdata_o = CW'(st_q.mask);
            SEL_PEND: csr_rdata_o[PBIT] = pend;
            SEL_IEN:  csr_rdata_o[PBIT] = ien;
            default:  csr_rdata_o = '0;
        endcase
    end

    AST_USER_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && sel == SEL_SUM) |-> (csr_rdata_o == '0)); // R5
    AST_FIXED_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_SUM) |-> (csr_rdata_o[FIRST-1:0] == '0)); // R9
    AST_FIXED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SEL_CNT || sel == SEL_EVT) && csr_idx_i < IDXW'(FIRST)) |-> (csr_rdata_o == '0)); // R9
endmodule

// File: tb/sim_ovf_irq_unit.sv
`timescale 1ns/1ps
module sim_ovf_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  priv = 2'b11;
    logic [28:0] inc = '0;
    logic        we = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic [4:0]  idx = 5'd0;
    logic [63:0] wd = '0;
    logic [63:0] rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [63:0] m_cnt [32];
    logic        m_of  [32];
    logic [7:0]  m_evs [32];
    logic [31:0] m_mask;
    logic        m_pend, m_ien;

    always #10 clk = ~clk;

    ovf_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .priv_i(priv), .ev_inc_i(inc),
        .csr_we_i(we), .csr_sel_i(sel), .csr_idx_i(idx), .csr_wdata_i(wd),
        .csr_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FIL_GUARD");
        end
    endtask

    function automatic logic [63:0] mrd(input logic [2:0] s, input logic [4:0] i, input logic [1:0] p);
        logic [63:0] r = '0;
        case (s)
            3'd0: if (i >= 3) r = m_cnt[i];
            3'd1: if (i >= 3) r = {m_of[i], 55'd0, m_evs[i]};
            3'd2: if (p != 2'b00) for (int k = 3; k < 32; k++) r[k] = m_of[k] & m_mask[k];
            3'd3: r = {32'd0, m_mask};
            3'd4: r[13] = m_pend;
            3'd5: r[13] = m_ien;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] s, input logic [4:0] i);
        if (s <= 3'd1 && i < 3) return "R9";
        case (s)
            3'd0: return "R2";
            3'd1: return "R4";
            3'd2, 3'd3: return "R5";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic model_step();
        bit rise = 0;
        for (int i = 3; i < 32; i++) begin
            bit wc   = we && sel == 3'd0 && idx == 5'(i);
            bit wev  = we && sel == 3'd1 && idx == 5'(i);
            bit wrap = inc[i-3] && !wc && (m_cnt[i] == '1);
            logic nof = wev ? wd[63] : (m_of[i] | wrap);
            m_cnt[i] = wc ? wd : m_cnt[i] + 64'(inc[i-3]);
            if (wev) m_evs[i] = wd[7:0];
            if (nof && !m_of[i]) rise = 1;
            m_of[i] = nof;
        end
        if (we && sel == 3'd3) m_mask = wd[31:0];
        if (we && sel == 3'd4) m_pend = wd[13];
        else if (rise) m_pend = 1'b1;
        if (we && sel == 3'd5) m_ien = wd[13];
    endtask

    task automatic cyc(input bit w, input logic [2:0] s, input logic [4:0] i,
                       input logic [63:0] d, input logic [28:0] c, input logic [1:0] p);
        we = w; sel = s; idx = i; wd = d; inc = c; priv = p;
        #2;
        check(tag_of(s, i), rdata, mrd(s, i, p));
        check("R8", 64'(irq), 64'(m_pend & m_ien));
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic peek(input logic [2:0] s, input logic [4:0] i, input logic [1:0] p,
                        input string tag, input logic [63:0] exp);
        we = 1'b0; sel = s; idx = i; inc = '0; priv = p; wd = '0;
        #2;
        check(tag, rdata, exp);
    endtask

    localparam logic [63:0] ONES = '1;

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_cnt[i] = '0; m_of[i] = 1'b0; m_evs[i] = '0;
        end
        m_mask = '0; m_pend = 1'b0; m_ien = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        peek(3'd0, 5'd5, 2'b11, "R1", 64'd0);
        peek(3'd1, 5'd5, 2'b11, "R1", 64'd0);
        peek(3'd4, 5'd0, 2'b11, "R1", 64'd0);
        peek(3'd3, 5'd0, 2'b11, "R1", 64'd0);
        check("R1", 64'(irq), 64'd0);

        // R2/R3: load near all-ones, count, wrap
        cyc(1, 3'd0, 5'd5, ONES - 64'd1, 29'd0, 2'b11);
        cyc(0, 3'd0, 5'd5, 0, 29'h4, 2'b11);
        peek(3'd0, 5'd5, 2'b11, "R2", ONES);
        cyc(0, 3'd0, 5'd5, 0, 29'h4, 2'b11);
        peek(3'd0, 5'd5, 2'b11, "R3", 64'd0);
        peek(3'd1, 5'd5, 2'b11, "R3", 64'h8000_0000_0000_0000);
        peek(3'd4, 5'd0, 2'b11, "R6", 64'h2000);
        cyc(0, 3'd1, 5'd5, 0, 29'h4, 2'b11);
        peek(3'd1, 5'd5, 2'b11, "R3", 64'h8000_0000_0000_0000);

        // R8: enable interrupt
        cyc(1, 3'd5, 5'd0, 64'h2000, 29'd0, 2'b11);
        check("R8", 64'(irq), 64'd1);
        // R7: clear pending, flag remains
        cyc(1, 3'd4, 5'd0, 64'd0, 29'd0, 2'b11);
        check("R7", 64'(irq), 64'd0);
        peek(3'd1, 5'd5, 2'b11, "R7", 64'h8000_0000_0000_0000);
        // R7: software sets pending
        cyc(1, 3'd4, 5'd0, 64'h2000, 29'd0, 2'b11);
        check("R7", 64'(irq), 64'd1);
        cyc(1, 3'd4, 5'd0, 64'd0, 29'd0, 2'b11);

        // R4: same-cycle select write beats overflow
        cyc(1, 3'd0, 5'd7, ONES, 29'd0, 2'b11);
        cyc(1, 3'd1, 5'd7, 64'h0000_0000_0000_00A5, 29'h10, 2'b11);
        peek(3'd1, 5'd7, 2'b11, "R4", 64'h0000_0000_0000_00A5);
        peek(3'd0, 5'd7, 2'b11, "R2", 64'd0);
        peek(3'd4, 5'd0, 2'b11, "R6", 64'd0);
        // R6: software flag set raises pending
        cyc(1, 3'd1, 5'd9, 64'h8000_0000_0000_0001, 29'd0, 2'b11);
        peek(3'd4, 5'd0, 2'b11, "R6", 64'h2000);

        // R5: summary masking and privilege
        cyc(1, 3'd3, 5'd0, 64'hFFFF_FFFF_FFFF_FDFF, 29'd0, 2'b11);
        peek(3'd2, 5'd0, 2'b11, "R5", 64'h20);
        cyc(1, 3'd3, 5'd0, 64'h0000_0000_FFFF_FFFF, 29'd0, 2'b01);
        peek(3'd2, 5'd0, 2'b01, "R5", 64'h220);
        peek(3'd2, 5'd0, 2'b00, "R5", 64'd0);

        // R9: reserved indices
        cyc(1, 3'd0, 5'd1, 64'h1234, 29'd0, 2'b11);
        cyc(1, 3'd1, 5'd2, ONES, 29'd0, 2'b11);
        peek(3'd0, 5'd1, 2'b11, "R9", 64'd0);
        peek(3'd1, 5'd2, 2'b11, "R9", 64'd0);

        // mixed pseudo-random traffic
        for (int n = 0; n < 600; n++) begin
            logic [2:0]  s = 3'($urandom_range(0, 6));
            logic [63:0] d = {$urandom, $urandom};
            logic [1:0]  p = ($urandom_range(0, 2) == 0) ? 2'b00 : (($urandom_range(0, 1) == 0) ? 2'b01 : 2'b11);
            if (s == 3'd0 && $urandom_range(0, 1) == 0) d = ONES - 64'($urandom_range(0, 3));
            if (s == 3'd1 && $urandom_range(0, 1) == 0) d[63] = 1'b0;
            cyc($urandom_range(0, 2) == 0, s, 5'($urandom_range(0, 31)), d, 29'($urandom), p);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule